// File: doc/BRIEF.md
# Descriptor-in-Memory Word Transfer Channel

This block moves single data words between a peripheral and main memory on behalf of one device. The channel keeps no pointer of its own. The running buffer pointer and the last buffer address sit in a two-word descriptor in main memory. The block only holds the base address of that descriptor, which is a configurable input. The current pointer is the lower word of the descriptor, and the end address is the word directly above it.

Each time the device raises its request, the channel makes four accesses through a single-port memory port. Each access waits for its own grant. The four accesses are:
1. Read the pointer.
2. Read the end address.
3. Move the data word at the pointer, in the direction selected by a direction input.
4. Store the advanced pointer back into the descriptor.

The channel then acknowledges the device. On the word whose pointer equals the end address, it also raises a one-cycle end-of-range pulse. After that pulse it stays idle until it is rearmed.

Top module: `mdc_dma_channel`

## Requirements
- R1: While reset is held and just after it is released, `mem_req`, `dev_ack` and `eor` are all low.
- R2: Each accepted device request results in exactly four granted memory accesses. These are followed by `dev_ack` high for exactly one cycle. A request still high in the acknowledge cycle does not start another word.
- R3: The four accesses occur in a fixed order. First a read at `desc_base`. Second a read at `desc_base+1`. Third a data access at the pointer value just read. Fourth a write at `desc_base` of the pointer plus one. All address arithmetic is modulo 2^AW.
- R4: With `dir_out` = 0 (device to memory), the value on `dev_wdata` when the request was accepted is written at the pointer address.
- R5: With `dir_out` = 1 (memory to device), the word read at the pointer address appears on `dev_rdata` while `dev_ack` is high, and memory is not written at that address.
- R6: While `mem_req` is high without `mem_gnt`, the request, address, write enable and write data stay unchanged. Any number of stall cycles leaves the transferred data and the stored pointer unchanged.
- R7: When the pointer read from memory equals the end address read from memory, `eor` is high for exactly one cycle, in the same cycle as `dev_ack`. On every other word `eor` stays low.
- R8: After `eor`, device requests are ignored: no memory request and no acknowledge. This lasts until `arm` is pulsed high for one cycle.
- R9: The descriptor base is taken from `desc_base`. The end-address word is found at `desc_base+1`, wrapping from the top address to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_base | input | AW | Address of the descriptor's pointer word |
| dir_out | input | 1 | 1: memory to device, 0: device to memory |
| arm | input | 1 | One-cycle pulse that clears the halt after end of range |
| dev_req | input | 1 | Device word request (level) |
| dev_wdata | input | DW | Word from the device, sampled when the request is accepted |
| dev_ack | output | 1 | One-cycle acknowledge at the end of a word |
| dev_rdata | output | DW | Word read for the device, valid with `dev_ack` |
| eor | output | 1 | One-cycle end-of-range pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Grant; the access completes in a cycle with request and grant both high |
| mem_rdata | input | DW | Read data, valid in the granted cycle |

## Verification
The bench builds the channel with AW = 8 and DW = 16. This makes the whole address space a 256-word array held in the bench. Descriptors can therefore be placed at an ordinary base and at the top address, where the end word wraps to address 0. The bench sweeps both directions, buffer lengths of one to three words and fixed stall counts of 0, 1, 3 and 7 cycles per access. For each word it computes the expected pointer, data and end-of-range flag arithmetically. It also probes the halt after every buffer with a request held for many cycles.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  localparam int MDC_MAXW = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CUR,
    ST_RD_END,
    ST_XFER,
    ST_WB
  } mdc_state_e;

  // Pointer advance; the caller keeps only its own address width.
  function automatic logic [MDC_MAXW-1:0] ptr_step(input logic [MDC_MAXW-1:0] p);
    return p + 1;
  endfunction

  // The word at the pointer is the last one of the buffer.
  function automatic logic last_word(input logic [MDC_MAXW-1:0] cur,
                                     input logic [MDC_MAXW-1:0] endp);
    return cur == endp;
  endfunction

endpackage

// File: rtl/mdc_seq.sv
module mdc_seq
  import mdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fire,
  output mdc_state_e state,
  output logic       word_done
);

  mdc_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:   if (start) state_q <= ST_RD_CUR;
        ST_RD_CUR: if (fire)  state_q <= ST_RD_END;
        ST_RD_END: if (fire)  state_q <= ST_XFER;
        ST_XFER:   if (fire)  state_q <= ST_WB;
        ST_WB:     if (fire)  state_q <= ST_IDLE;
        default:              state_q <= ST_IDLE;
      endcase
    end
  end

  assign state     = state_q;
  assign word_done = (state_q == ST_WB) && fire;

endmodule

// File: rtl/mdc_desc.sv
module mdc_desc
  import mdc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mdc_state_e    state,
  input  logic          fire,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] cur,
  output logic [AW-1:0] nxt,
  output logic          at_end
);

  logic [AW-1:0]       cur_q;
  logic [AW-1:0]       end_q;
  logic [MDC_MAXW-1:0] step_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      end_q <= '0;
    end else if (fire) begin
      if (state == ST_RD_CUR) cur_q <= mem_rdata[AW-1:0];
      if (state == ST_RD_END) end_q <= mem_rdata[AW-1:0];
    end
  end

  assign step_w = ptr_step(MDC_MAXW'(cur_q));
  assign cur    = cur_q;
  assign nxt    = step_w[AW-1:0];
  assign at_end = last_word(MDC_MAXW'(cur_q), MDC_MAXW'(end_q));

endmodule

// File: rtl/mdc_port_mux.sv
module mdc_port_mux
  import mdc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  mdc_state_e    state,
  input  logic [AW-1:0] desc_base,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] nxt,
  input  logic          dir_q,
  input  logic [DW-1:0] wdata_q,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  logic [AW-1:0] end_addr;
  assign end_addr = desc_base + 1'b1;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_RD_CUR: begin
        mem_req  = 1'b1;
        mem_addr = desc_base;
      end
      ST_RD_END: begin
        mem_req  = 1'b1;
        mem_addr = end_addr;
      end
      ST_XFER: begin
        mem_req   = 1'b1;
        mem_we    = ~dir_q;
        mem_addr  = cur;
        mem_wdata = wdata_q;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_base;
        mem_wdata = DW'(nxt);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mdc_dma_channel.sv
module mdc_dma_channel
  import mdc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] desc_base,
  input  logic          dir_out,
  input  logic          arm,
  input  logic          dev_req,
  input  logic [DW-1:0] dev_wdata,
  output logic          dev_ack,
  output logic [DW-1:0] dev_rdata,
  output logic          eor,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata
);

  mdc_state_e    state;
  logic          grant_fire;
  logic          word_done;
  logic          start;
  logic          last_hit;
  logic [AW-1:0] cur;
  logic [AW-1:0] nxt;
  logic          dir_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          ack_q;
  logic          eor_q;
  logic          halt_q;

  assign grant_fire = mem_req & mem_gnt;
  assign start      = (state == ST_IDLE) & dev_req & ~halt_q & ~ack_q;

  mdc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fire      (grant_fire),
    .state     (state),
    .word_done (word_done)
  );

  mdc_desc #(.AW(AW), .DW(DW)) u_desc (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .fire      (grant_fire),
    .mem_rdata (mem_rdata),
    .cur       (cur),
    .nxt       (nxt),
    .at_end    (last_hit)
  );

  mdc_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .state     (state),
    .desc_base (desc_base),
    .cur       (cur),
    .nxt       (nxt),
    .dir_q     (dir_q),
    .wdata_q   (wdata_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
      eor_q   <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      if (start) begin
        dir_q   <= dir_out;
        wdata_q <= dev_wdata;
      end
      if (grant_fire && state == ST_XFER && dir_q) rdata_q <= mem_rdata;
      ack_q  <= word_done;
      eor_q  <= word_done & last_hit;
      halt_q <= (halt_q & ~arm) | (word_done & last_hit);
    end
  end

  assign dev_ack   = ack_q;
  assign eor       = eor_q;
  assign dev_rdata = rdata_q;

endmodule

// File: rtl/mdc_dma_channel_chk.sv
module mdc_dma_channel_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] desc_base,
  input logic          arm,
  input logic          dev_ack,
  input logic          eor,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_gnt,
  input logic          grant_fire
);

  logic [2:0] gcnt;
  logic       halt_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcnt   <= '0;
      halt_m <= 1'b0;
    end else begin
      if (dev_ack)         gcnt <= '0;
      else if (grant_fire) gcnt <= gcnt + 3'd1;
      halt_m <= (halt_m | eor) & ~arm;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata)));

  // R2
  four_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (gcnt == 3'd4));

  // R3
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fire && gcnt == 3'd0) |-> (!mem_we && mem_addr == desc_base));

  // R3
  writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fire && gcnt == 3'd3) |-> (mem_we && mem_addr == desc_base));

  // R7
  eor_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eor |-> dev_ack);

  // R7
  eor_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eor |=> !eor);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_m |-> (!mem_req && !dev_ack));

endmodule

bind mdc_dma_channel mdc_dma_channel_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .desc_base  (desc_base),
  .arm        (arm),
  .dev_ack    (dev_ack),
  .eor        (eor),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_gnt    (mem_gnt),
  .grant_fire (grant_fire)
);

// File: tb/mdc_dma_channel_tb.sv
module mdc_dma_channel_tb;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] desc_base;
  logic          dir_out;
  logic          arm;
  logic          dev_req;
  logic [DW-1:0] dev_wdata;
  logic          dev_ack;
  logic [DW-1:0] dev_rdata;
  logic          eor;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_gnt;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] mem [256];
  int            stall_cfg;
  int            wait_cnt;
  int            nfire;
  logic          clr_fire;
  logic [AW-1:0] log_addr [4];
  logic          log_we   [4];
  int            n_chk;
  int            n_fail;

  always #10 clk = ~clk;

  mdc_dma_channel #(.AW(AW), .DW(DW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_base (desc_base),
    .dir_out   (dir_out),
    .arm       (arm),
    .dev_req   (dev_req),
    .dev_wdata (dev_wdata),
    .dev_ack   (dev_ack),
    .dev_rdata (dev_rdata),
    .eor       (eor),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  assign mem_gnt   = mem_req && (wait_cnt >= stall_cfg);

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      wait_cnt <= 0;
    end else if (mem_req) begin
      wait_cnt <= wait_cnt + 1;
    end
    if (clr_fire) begin
      nfire <= 0;
    end else if (mem_req && mem_gnt) begin
      if (nfire < 4) begin
        log_addr[nfire] <= mem_addr;
        log_we[nfire]   <= mem_we;
      end
      nfire <= nfire + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] in_pat(input int b, input int w, input int s);
    return DW'(16'h5000 + b * 64 + w * 8 + s);
  endfunction

  function automatic logic [DW-1:0] out_pat(input int b, input int w, input int s);
    return DW'(16'hA000 + b * 64 + w * 8 + s);
  endfunction

  task automatic run_case(input int base, input logic dir, input int len, input int stall);
    logic [AW-1:0] b0;
    logic [AW-1:0] b1;
    logic [AW-1:0] bufs;
    b0   = AW'(base);
    b1   = AW'(base + 1);
    bufs = 8'h80;
    @(negedge clk);
    stall_cfg = stall;
    desc_base = b0;
    mem[b0]   = DW'(bufs);
    mem[b1]   = DW'(bufs + AW'(len - 1));
    for (int i = 0; i < 4; i++) mem[bufs + AW'(i)] = out_pat(base, i, stall);
    for (int w = 0; w < len; w++) begin
      logic [AW-1:0] cur;
      logic          got;
      cur       = bufs + AW'(w);
      dev_req   = 1'b1;
      dir_out   = dir;
      dev_wdata = in_pat(base, w, stall);
      clr_fire  = 1'b1;
      @(negedge clk);
      clr_fire  = 1'b0;
      got = 1'b0;
      for (int t = 0; t < 400 && !got; t++) begin
        if (dev_ack) got = 1'b1;
        else @(negedge clk);
      end
      check(got, "R2 ack arrives", int'(got), 1);
      dev_req = 1'b0;
      // R2: four granted accesses per word
      check(nfire == 4, "R2 access count", nfire, 4);
      // R3 / R9: access order and descriptor addresses
      check(log_addr[0] == b0 && !log_we[0], "R3 first read at base", int'(log_addr[0]), int'(b0));
      check(log_addr[1] == b1 && !log_we[1], "R9 end word at base+1", int'(log_addr[1]), int'(b1));
      check(log_addr[2] == cur && log_we[2] == !dir, "R3 data access at pointer", int'(log_addr[2]), int'(cur));
      check(log_addr[3] == b0 && log_we[3], "R3 write-back at base", int'(log_addr[3]), int'(b0));
      check(mem[b0] == DW'(cur + 1'b1), "R6 stored pointer advanced", int'(mem[b0]), int'(cur + 1'b1));
      if (dir) begin
        check(dev_rdata == out_pat(base, w, stall), "R5 word to device", int'(dev_rdata),
              int'(out_pat(base, w, stall)));
        check(mem[cur] == out_pat(base, w, stall), "R5 memory untouched", int'(mem[cur]),
              int'(out_pat(base, w, stall)));
      end else begin
        check(mem[cur] == in_pat(base, w, stall), "R4 word from device", int'(mem[cur]),
              int'(in_pat(base, w, stall)));
      end
      check(eor == (w == len - 1), "R7 end-of-range flag", int'(eor), int'(w == len - 1));
      @(negedge clk);
      check(!dev_ack && !eor, "R7 pulses last one cycle", int'({dev_ack, eor}), 0);
    end
    // R8: requests ignored until rearmed
    dev_req = 1'b1;
    begin
      logic busy;
      busy = 1'b0;
      for (int t = 0; t < 30; t++) begin
        @(negedge clk);
        if (mem_req || dev_ack) busy = 1'b1;
      end
      check(!busy, "R8 halted after end of range", int'(busy), 0);
    end
    dev_req = 1'b0;
    arm     = 1'b1;
    @(negedge clk);
    arm     = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    desc_base = '0;
    dir_out   = 1'b0;
    arm       = 1'b0;
    dev_req   = 1'b0;
    dev_wdata = '0;
    stall_cfg = 0;
    wait_cnt  = 0;
    nfire     = 0;
    clr_fire  = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!mem_req && !dev_ack && !eor, "R1 outputs low in reset", int'({mem_req, dev_ack, eor}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !dev_ack && !eor, "R1 outputs low after reset", int'({mem_req, dev_ack, eor}), 0);
    for (int bi = 0; bi < 2; bi++)
      for (int d = 0; d < 2; d++)
        for (int len = 1; len <= 3; len++)
          for (int si = 0; si < 4; si++)
            run_case(bi == 0 ? 8'h10 : 8'hFF, d[0], len, (si == 3) ? 7 : (si == 2 ? 3 : si));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule